// File: doc/BRIEF.md
# Execution ALU with Conditional Trap Select

This block is the arithmetic and logic unit of an execution pipeline. Each cycle it takes two operand words, an operation code and a condition code, and produces a result word and a trap code. It supports signed, unsigned, tag-checked and plain add and subtract, bitwise AND, OR and XOR, and a bounds check. The condition code picks one predicate, which can test the result, an arithmetic flag or a fixed value. When that predicate is true, the trap code output repeats the condition code. When it is false, the trap code output is zero, meaning no fault.

A single carry flag persists between operations. It is modelled as a two-state machine with the states `CF_CLEAR` and `CF_SET`. On a rising edge with `issue` high and a zero trap code, the operation's carry rule can take one of these transitions:

- `LOAD_SET` moves the flag to `CF_SET`.
- `LOAD_CLEAR` moves the flag to `CF_CLEAR`.
- `HOLD` keeps the current state.

With `issue` low, or with a nonzero trap code, the flag always holds. A synchronous reset forces `CF_CLEAR`.

The tag check treats the top `TAG_BITS` bits of a word as the tag of a small integer, which is legal only when those bits are all equal. The kernel-limit condition compares the unsigned result against the parameter `KERNEL_LIMIT`.

Top module: `alu_trap_unit`

## Requirements
- R1: Signed add (op 0) and unsigned add (op 1) give result = A + B + carry flag, modulo 2^WIDTH. With no trap, unsigned add loads the adder carry-out into the carry flag, and signed add clears the flag.
- R2: Signed add raises overflow when A and B have the same sign bit and the result sign differs from it. Signed subtract (op 2) raises overflow when the signs of A and B differ and the result sign differs from A.
- R3: Signed and unsigned subtract (ops 2, 3) give result = A + NOT B + NOT carry, which equals A − B − carry. With no trap, unsigned subtract loads the borrow (A < B + carry) into the carry flag, and signed subtract clears the flag.
- R4: Tagged add (op 4) gives A + B and tagged subtract (op 5) gives A − B, both ignoring the carry flag. Each raises illegal-tag when the top TAG_BITS bits of A, of B or of the result are not all equal. With no trap, both clear the carry flag.
- R5: Plain add (op 6) gives A + B and plain subtract (op 7) gives A − B, both ignoring the carry flag. Neither changes the carry flag.
- R6: AND (op 8), OR (op 9) and XOR (op 10) give the bitwise result, always report trap code 0 and leave the carry flag unchanged. Op codes 12–15 behave the same way, with result 0.
- R7: Bounds check (op 11) returns A unchanged and raises bound-violation exactly when A >= B unsigned. It leaves the carry flag unchanged.
- R8: The trap code equals the condition code when the selected predicate holds, and is 0 otherwise. The predicates are: 0 never, 1 result zero, 2 result negative, 3 result <= 0 (signed), 4 always, 5 result nonzero, 6 result >= 0, 7 result > 0, 8 overflow, 9 bound violation, 10 illegal tag, 11 no overflow, 12 no bound violation, 13 tag legal, 15 never.
- R9: Condition 14 traps when the result, read as unsigned, is below KERNEL_LIMIT.
- R10: The carry flag changes only on a rising edge with issue high and trap code 0.
- R11: A synchronous reset clears the carry flag. With issue low, the carry flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation is issued this cycle (allows the carry commit) |
| op | input | 4 | Operation code |
| cond | input | 4 | Trap condition select |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| result | output | WIDTH | Result word (combinational) |
| trap_code | output | 4 | Condition code if its predicate holds, else 0 (combinational) |
| carry_flag | output | 1 | Registered carry flag |

## Verification
The result and trap code depend only on the present inputs and the current carry flag, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these two outputs 5 ns later, before the next rising edge.

The carry flag is due one rising edge after the issued operation. The bench reads it 1 ns after that edge.

Each sweep step first forces the carry flag to a known value with a one-cycle setup operation, then applies the operation under test. Expected values come from integer arithmetic on an 8-bit configuration.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;

    typedef enum logic [3:0] {
        OP_SADD = 4'd0,
        OP_UADD = 4'd1,
        OP_SSUB = 4'd2,
        OP_USUB = 4'd3,
        OP_TADD = 4'd4,
        OP_TSUB = 4'd5,
        OP_PADD = 4'd6,
        OP_PSUB = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_BCHK = 4'd11
    } alu_op_e;

    typedef enum logic [3:0] {
        CD_NEVER   = 4'd0,
        CD_ZERO    = 4'd1,
        CD_NEG     = 4'd2,
        CD_LEZ     = 4'd3,
        CD_ALWAYS  = 4'd4,
        CD_NONZERO = 4'd5,
        CD_GEZ     = 4'd6,
        CD_GTZ     = 4'd7,
        CD_OVF     = 4'd8,
        CD_BND     = 4'd9,
        CD_TAGBAD  = 4'd10,
        CD_NOOVF   = 4'd11,
        CD_NOBND   = 4'd12,
        CD_TAGOK   = 4'd13,
        CD_KERNEL  = 4'd14,
        CD_SPARE   = 4'd15
    } alu_cond_e;

    typedef enum logic {
        CF_CLEAR = 1'b0,
        CF_SET   = 1'b1
    } carry_state_e;

    typedef enum logic [1:0] {
        CM_HOLD,
        CM_LOAD_COUT,
        CM_LOAD_BORROW,
        CM_LOAD_ZERO
    } carry_mode_e;

    typedef enum logic [2:0] {
        RS_SUM,
        RS_A,
        RS_AND,
        RS_OR,
        RS_XOR,
        RS_ZERO
    } res_sel_e;

    typedef struct packed {
        logic ovf;
        logic bnd;
        logic tagbad;
    } alu_flags_t;

endpackage

// File: rtl/alu_trap_adder.sv
module alu_trap_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = x[i] ^ y[i] ^ chain[i];
        assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/alu_trap_core.sv
module alu_trap_core
    import alu_trap_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int TAG_BITS = 3
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_q,
    output logic [WIDTH-1:0] result,
    output alu_flags_t       flags,
    output carry_mode_e      carry_mode,
    output logic             adder_cout,
    output logic             trap_ok
);
    localparam int MSB = WIDTH - 1;

    logic             invert_b;
    logic             add_cin;
    res_sel_e         res_sel;
    logic [WIDTH-1:0] b_opnd;
    logic [WIDTH-1:0] sum;

    // Operation decode: adder set-up, result source, carry rule.
    always_comb begin
        invert_b   = 1'b0;
        add_cin    = 1'b0;
        res_sel    = RS_SUM;
        carry_mode = CM_HOLD;
        trap_ok    = 1'b1;
        unique case (op)
            OP_SADD: begin
                add_cin    = carry_q;
                carry_mode = CM_LOAD_ZERO;
            end
            OP_UADD: begin
                add_cin    = carry_q;
                carry_mode = CM_LOAD_COUT;
            end
            OP_SSUB: begin
                invert_b   = 1'b1;
                add_cin    = ~carry_q;
                carry_mode = CM_LOAD_ZERO;
            end
            OP_USUB: begin
                invert_b   = 1'b1;
                add_cin    = ~carry_q;
                carry_mode = CM_LOAD_BORROW;
            end
            OP_TADD: begin
                carry_mode = CM_LOAD_ZERO;
            end
            OP_TSUB: begin
                invert_b   = 1'b1;
                add_cin    = 1'b1;
                carry_mode = CM_LOAD_ZERO;
            end
            OP_PADD: begin
                carry_mode = CM_HOLD;
            end
            OP_PSUB: begin
                invert_b = 1'b1;
                add_cin  = 1'b1;
            end
            OP_AND: begin
                res_sel = RS_AND;
                trap_ok = 1'b0;
            end
            OP_OR: begin
                res_sel = RS_OR;
                trap_ok = 1'b0;
            end
            OP_XOR: begin
                res_sel = RS_XOR;
                trap_ok = 1'b0;
            end
            OP_BCHK: begin
                invert_b = 1'b1;
                add_cin  = 1'b1;
                res_sel  = RS_A;
            end
            default: begin
                res_sel = RS_ZERO;
                trap_ok = 1'b0;
            end
        endcase
    end

    assign b_opnd = invert_b ? ~b : b;

    alu_trap_adder #(.WIDTH(WIDTH)) u_adder (
        .x    (a),
        .y    (b_opnd),
        .cin  (add_cin),
        .sum  (sum),
        .cout (adder_cout)
    );

    always_comb begin
        unique case (res_sel)
            RS_SUM:  result = sum;
            RS_A:    result = a;
            RS_AND:  result = a & b;
            RS_OR:   result = a | b;
            RS_XOR:  result = a ^ b;
            default: result = '0;
        endcase
    end

    function automatic logic tag_legal(input logic [WIDTH-1:0] w);
        logic [TAG_BITS-1:0] t;
        t = w[MSB -: TAG_BITS];
        return (t == '0) || (t == '1);
    endfunction

    always_comb begin
        flags.ovf = 1'b0;
        if (op == OP_SADD)
            flags.ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        else if (op == OP_SSUB)
            flags.ovf = (a[MSB] != b[MSB]) && (sum[MSB] != a[MSB]);
        flags.bnd    = (op == OP_BCHK) && adder_cout;
        flags.tagbad = ((op == OP_TADD) || (op == OP_TSUB)) &&
                       !(tag_legal(a) && tag_legal(b) && tag_legal(sum));
    end
endmodule

// File: rtl/alu_trap_cond.sv
module alu_trap_cond
    import alu_trap_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter int KERNEL_LIMIT = 32'h0000_4000
) (
    input  logic [3:0]       cond,
    input  logic [WIDTH-1:0] result,
    input  alu_flags_t       flags,
    input  logic             trap_ok,
    output logic [3:0]       trap_code
);
    localparam logic [WIDTH-1:0] KLIM = WIDTH'(KERNEL_LIMIT);

    alu_cond_e sel;
    logic      is_zero;
    logic      is_neg;
    logic      hit;

    assign sel     = alu_cond_e'(cond);
    assign is_zero = (result == '0);
    assign is_neg  = result[WIDTH-1];

    always_comb begin
        unique case (sel)
            CD_NEVER:   hit = 1'b0;
            CD_ZERO:    hit = is_zero;
            CD_NEG:     hit = is_neg;
            CD_LEZ:     hit = is_neg | is_zero;
            CD_ALWAYS:  hit = 1'b1;
            CD_NONZERO: hit = !is_zero;
            CD_GEZ:     hit = !is_neg;
            CD_GTZ:     hit = !is_neg && !is_zero;
            CD_OVF:     hit = flags.ovf;
            CD_BND:     hit = flags.bnd;
            CD_TAGBAD:  hit = flags.tagbad;
            CD_NOOVF:   hit = !flags.ovf;
            CD_NOBND:   hit = !flags.bnd;
            CD_TAGOK:   hit = !flags.tagbad;
            CD_KERNEL:  hit = (result < KLIM);
            default:    hit = 1'b0;
        endcase
    end

    assign trap_code = (hit && trap_ok) ? cond : 4'd0;
endmodule

// File: rtl/alu_trap_unit.sv
module alu_trap_unit
    import alu_trap_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter int TAG_BITS     = 3,
    parameter int KERNEL_LIMIT = 32'h0000_4000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [3:0]       op,
    input  logic [3:0]       cond,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       trap_code,
    output logic             carry_flag
);
    carry_state_e state_q;
    carry_state_e state_d;
    alu_flags_t   flags;
    carry_mode_e  carry_mode;
    logic         adder_cout;
    logic         trap_ok;
    logic         commit;
    logic         load_one;
    logic         load_zero;

    alu_trap_core #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS)) u_core (
        .op         (alu_op_e'(op)),
        .a          (a),
        .b          (b),
        .carry_q    (state_q == CF_SET),
        .result     (result),
        .flags      (flags),
        .carry_mode (carry_mode),
        .adder_cout (adder_cout),
        .trap_ok    (trap_ok)
    );

    alu_trap_cond #(.WIDTH(WIDTH), .KERNEL_LIMIT(KERNEL_LIMIT)) u_cond (
        .cond      (cond),
        .result    (result),
        .flags     (flags),
        .trap_ok   (trap_ok),
        .trap_code (trap_code)
    );

    assign commit = issue && (trap_code == 4'd0);

    always_comb begin
        load_one  = 1'b0;
        load_zero = 1'b0;
        unique case (carry_mode)
            CM_HOLD: ;
            CM_LOAD_COUT: begin
                load_one  = adder_cout;
                load_zero = !adder_cout;
            end
            CM_LOAD_BORROW: begin
                load_one  = !adder_cout;
                load_zero = adder_cout;
            end
            CM_LOAD_ZERO: load_zero = 1'b1;
            default: ;
        endcase
    end

    // Carry flag state machine: transitions LOAD_SET, LOAD_CLEAR, HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CF_CLEAR: if (commit && load_one)  state_d = CF_SET;
            CF_SET:   if (commit && load_zero) state_d = CF_CLEAR;
            default:  state_d = CF_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CF_CLEAR;
        else     state_q <= state_d;
    end

    always_comb begin
        carry_flag = (state_q == CF_SET);
    end

    a_r10_trap_blocks_carry: assert property (@(posedge clk) disable iff (rst)
        (issue && trap_code != 4'd0) |=> $stable(carry_flag));

    a_r11_idle_holds_carry: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(carry_flag));

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> !carry_flag);

    a_r5_plain_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (issue && (op == 4'd6 || op == 4'd7)) |=> $stable(carry_flag));

    a_r6_logic_no_trap: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd8 || op == 4'd9 || op == 4'd10) |-> trap_code == 4'd0);

    a_r7_bounds_passes_a: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd11) |-> result == a);

    a_r8_trap_mirrors_cond: assert property (@(posedge clk) disable iff (rst)
        (trap_code != 4'd0) |-> trap_code == cond);
endmodule

// File: tb/tb_alu_trap_unit.sv
module tb_alu_trap_unit;
    localparam int W = 8;
    localparam int KL = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         issue = 1'b0;
    logic [3:0]   op = '0;
    logic [3:0]   cond = '0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] result;
    logic [3:0]   trap_code;
    logic         carry_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    alu_trap_unit #(.WIDTH(W), .TAG_BITS(3), .KERNEL_LIMIT(KL)) dut (
        .clk(clk), .rst(rst), .issue(issue), .op(op), .cond(cond),
        .a(a), .b(b), .result(result), .trap_code(trap_code),
        .carry_flag(carry_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s op=%0d cond=%0d a=%0h b=%0h actual=%0h expected=%0h",
                     req, op, cond, a, b, act, exp);
        end
    endtask

    function automatic int tag_ok(input int x);
        return ((x >> 5) == 0 || (x >> 5) == 7) ? 1 : 0;
    endfunction

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    task automatic model(input int o, input int cd, input int x, input int y,
                         input int c, output int res, output int trap, output int nc);
        int s;
        int ovf = 0, bnd = 0, tagbad = 0, suppress = 0, hit = 0, sr;
        nc = c;
        case (o)
            0: begin s = sgn(x) + sgn(y) + c; res = (x + y + c) & 255;
                     ovf = (s > 127 || s < -128); nc = 0; end
            1: begin res = (x + y + c) & 255; nc = ((x + y + c) > 255); end
            2: begin s = sgn(x) - sgn(y) - c; res = (x - y - c) & 255;
                     ovf = (s > 127 || s < -128); nc = 0; end
            3: begin res = (x - y - c) & 255; nc = ((x - y - c) < 0); end
            4: begin res = (x + y) & 255; nc = 0; end
            5: begin res = (x - y) & 255; nc = 0; end
            6: res = (x + y) & 255;
            7: res = (x - y) & 255;
            8: begin res = x & y; suppress = 1; end
            9: begin res = x | y; suppress = 1; end
            10: begin res = x ^ y; suppress = 1; end
            11: begin res = x; bnd = (x >= y); end
            default: begin res = 0; suppress = 1; end
        endcase
        if (o == 4 || o == 5)
            tagbad = !(tag_ok(x) && tag_ok(y) && tag_ok(res));
        sr = sgn(res);
        case (cd)
            1: hit = (res == 0);
            2: hit = (sr < 0);
            3: hit = (sr <= 0);
            4: hit = 1;
            5: hit = (res != 0);
            6: hit = (sr >= 0);
            7: hit = (sr > 0);
            8: hit = ovf;
            9: hit = bnd;
            10: hit = tagbad;
            11: hit = !ovf;
            12: hit = !bnd;
            13: hit = !tagbad;
            14: hit = (res < KL);
            default: hit = 0;
        endcase
        trap = (hit && !suppress) ? cd : 0;
        if (trap != 0) nc = c;
    endtask

    function automatic string res_req(input int o);
        if (o <= 1) return "R1";
        if (o <= 3) return "R3";
        if (o <= 5) return "R4";
        if (o <= 7) return "R5";
        if (o == 11) return "R7";
        return "R6";
    endfunction

    function automatic string trap_req(input int o, input int cd);
        if (cd == 14) return "R9";
        if (o == 0 && (cd == 8 || cd == 11)) return "R2";
        if (o == 2 && (cd == 8 || cd == 11)) return "R2";
        if ((o == 4 || o == 5) && (cd == 10 || cd == 13)) return "R4";
        if (o == 11 && (cd == 9 || cd == 12)) return "R7";
        if (o >= 8 && o != 11) return "R6";
        return "R8";
    endfunction

    function automatic string carry_req(input int o);
        if (o == 6 || o == 7) return "R5";
        if (o == 11) return "R7";
        if (o >= 8) return "R6";
        return "R10";
    endfunction

    // Force the carry flag to a known value, one issued op, checked after the edge.
    task automatic set_carry(input int c);
        @(negedge clk);
        issue = 1'b1;
        cond = 4'd0;
        if (c != 0) begin op = 4'd1; a = 8'hFF; b = 8'h01; end
        else        begin op = 4'd0; a = 8'h00; b = 8'h00; end
        @(posedge clk);
        #1;
        chk("R10", int'(carry_flag), c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int vals[8] = '{0, 1, 8'h1F, 8'h20, 8'h7F, 8'h80, 8'hE0, 8'hFF};
        int er, et, ec;

        // R11: carry clears under reset
        repeat (3) @(posedge clk);
        #1;
        chk("R11", int'(carry_flag), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int o = 0; o < 16; o++) begin
            for (int cd = 0; cd < 16; cd++) begin
                for (int ia = 0; ia < 8; ia++) begin
                    for (int ib = 0; ib < 8; ib++) begin
                        for (int c = 0; c < 2; c++) begin
                            set_carry(c);
                            @(negedge clk);
                            issue = 1'b1;
                            op = 4'(o);
                            cond = 4'(cd);
                            a = 8'(vals[ia]);
                            b = 8'(vals[ib]);
                            model(o, cd, vals[ia], vals[ib], c, er, et, ec);
                            #5;
                            chk(res_req(o), int'(result), er);
                            chk(trap_req(o, cd), int'(trap_code), et);
                            @(posedge clk);
                            #1;
                            chk(carry_req(o), int'(carry_flag), ec);
                        end
                    end
                end
            end
        end

        // R11: issue low leaves carry unchanged (a clearing op is presented)
        set_carry(1);
        @(negedge clk);
        issue = 1'b0;
        op = 4'd0;
        cond = 4'd0;
        a = 8'h00;
        b = 8'h00;
        @(posedge clk);
        #1;
        chk("R11", int'(carry_flag), 1);

        // R11: reset wins over a carry-setting issued op
        set_carry(0);
        @(negedge clk);
        rst = 1'b1;
        issue = 1'b1;
        op = 4'd1;
        a = 8'hFF;
        b = 8'h01;
        @(posedge clk);
        #1;
        chk("R11", int'(carry_flag), 0);
        @(negedge clk);
        rst = 1'b0;
        issue = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule